// File: doc/BRIEF.md
# Three-Channel PCM Transmit Serializer

This block turns three 8-bit companded voice samples into serial bit streams, once per 8 kHz frame. It runs on the line bit clock: a rising edge on the transmit frame sync starts a frame, and each following bit clock shifts one more bit out. Samples are handed over as one 24-bit triplet through a valid/ready port. The triplet waits in a one-entry holding stage and is copied into the shifters when the next frame starts.

A layout input picks one of two layouts. In split layout, each channel has its own serial line and all three send their 8 bits in the same slots. In chained layout, the three bytes go out back to back on line 0 (channel 0 first), and lines 1 and 2 stay idle. Each line is modelled as an open-drain driver, with a data bit and an output enable. Outside its own bit slots a line is released. A global power input and one enable per channel decide the state of each line. With the block unpowered, every line is released. With the block powered and a channel disabled, that channel sends the all-ones code in its slot.

Back-pressure on the sample port is simple. `smp_ready` is high exactly when the holding stage is empty. A triplet is taken on any edge where `smp_valid` and `smp_ready` are both high. The stage empties at the next frame start. If no new triplet has arrived by that frame, the previous triplet is sent again. The producer should load at most one triplet per frame. A triplet accepted on the same edge as a frame start is sent in the next frame.

Top module: `pcm_tx_serializer`

## Requirements
- R1: In split layout, each line sends its channel byte, most significant bit first, as exactly 8 consecutive enabled bit slots. Channel c occupies `smp_data[8c+7:8c]`.
- R2: A frame starts on the bit-clock edge at which `frame_sync` is first sampled high after being low. From that edge, every selected line is enabled and carries bit 7 of its byte.
- R3: In chained layout, line 0 sends 24 consecutive bits: channel 0, then channel 1, then channel 2, each MSB first. Lines 1 and 2 stay released for the whole frame.
- R4: A line whose output enable is low is released and drives a data value of 1. Every line is released outside its own bit slots.
- R5: While `pwr_on` is low, all lines are released from the next edge on, any running frame is abandoned, and sync edges start nothing.
- R6: While powered, a channel whose `ch_en` bit is 0 at frame start sends 8'hFF in its slot, in either layout.
- R7: After `pwr_on` rises, all lines stay released until a sync rising edge is seen.
- R8: `smp_ready` equals "holding stage empty". The triplet in the stage is used by the next frame start, which empties the stage. If the stage is empty at frame start, the last triplet sent is repeated. After reset, the last triplet is all ones.
- R9: A sync pulse lasting many bit clocks starts exactly one frame. Only its rising edge counts.
- R10: A sync rising edge during a running frame abandons that frame and starts a new one from bit 7.
- R11: After reset, all lines are released and `smp_ready` is high.
- R12: The layout (`chain_mode`, 1 = chained) and `ch_en` are sampled only at frame start. Changes made during a frame have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Line bit clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Transmit frame sync; rising edge starts a frame |
| chain_mode | input | 1 | 0 = split layout, 1 = chained layout |
| pwr_on | input | 1 | Global power; 0 releases every line |
| ch_en | input | 3 | Per-channel enable; 0 substitutes the all-ones code |
| smp_valid | input | 1 | Sample triplet offered |
| smp_ready | output | 1 | Holding stage empty |
| smp_data | input | 24 | Sample triplet, channel c in bits 8c+7:8c |
| tx_d | output | 3 | Serial data per line (1 when released) |
| tx_oe | output | 3 | Output enable per line (1 = driving) |

## Verification
The bench follows the edge timing of long sync pulses and of a second sync edge arriving mid-frame. A design that retriggers while the sync is held high would send a frame twice. One that ignores a mid-frame edge would shift stale bits. It changes layout and channel enables inside a frame, which catches a design that reads them live and cuts a chained frame off after 8 bits or drops fill bytes into the wrong slot. It removes power mid-frame and restores it with the sync low, so a design that resumes the abandoned frame or drives before a sync is caught. It also leaves frames with no new triplet, which shows up a design that sends zeros or stale stage contents instead of repeating the last triplet.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef enum logic {
    LAYOUT_SPLIT = 1'b0,
    LAYOUT_CHAIN = 1'b1
  } layout_e;
endpackage

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
  import pcm_tx_pkg::*;
#(
  parameter int NCH = 3,
  parameter int SW  = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sync_in,
  input  logic    pwr_on,
  input  logic    chain_req,
  output logic    frame_start,
  output logic    active,
  output layout_e layout_q
);
  localparam int MAXB = NCH * SW;
  localparam int CW   = $clog2(MAXB);

  logic          sync_q;
  logic [CW-1:0] idx;
  logic [CW-1:0] last_idx;

  assign frame_start = pwr_on & sync_in & ~sync_q;

  always_comb begin
    if (layout_q == LAYOUT_CHAIN) last_idx = CW'(MAXB - 1);
    else                          last_idx = CW'(SW - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      active   <= 1'b0;
      idx      <= '0;
      layout_q <= LAYOUT_SPLIT;
    end else begin
      sync_q <= sync_in;
      if (!pwr_on) begin
        active <= 1'b0;
        idx    <= '0;
      end else if (frame_start) begin
        active   <= 1'b1;
        idx      <= '0;
        layout_q <= chain_req ? LAYOUT_CHAIN : LAYOUT_SPLIT;
      end else if (active) begin
        if (idx == last_idx) begin
          active <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tx_stage.sv
module pcm_tx_stage #(
  parameter int          NCH  = 3,
  parameter int          SW   = 8,
  parameter logic [7:0]  FILL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NCH*SW-1:0]  in_data,
  input  logic               take,
  input  logic [NCH-1:0]     ch_en,
  output logic [NCH*SW-1:0]  frame_bytes
);
  localparam int TW = NCH * SW;

  logic          full;
  logic [TW-1:0] held;
  logic [TW-1:0] last_sent;
  logic [TW-1:0] src;

  assign in_ready = ~full;
  assign src      = full ? held : last_sent;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign frame_bytes[c*SW +: SW] = ch_en[c] ? src[c*SW +: SW] : SW'(FILL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held      <= '0;
      last_sent <= '1;
    end else begin
      if (take) begin
        last_sent <= src;
      end
      if (in_valid && in_ready) begin
        full <= 1'b1;
        held <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [LW-1:0] word,
  output logic          bit_o
);
  logic [LW-1:0] sr;

  assign bit_o = sr[LW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '1;
    else if (load)  sr <= word;
    else if (shift) sr <= {sr[LW-2:0], 1'b1};
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int         NCH  = 3,
  parameter int         SW   = 8,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              chain_mode,
  input  logic              pwr_on,
  input  logic [NCH-1:0]    ch_en,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [NCH*SW-1:0] smp_data,
  output logic [NCH-1:0]    tx_d,
  output logic [NCH-1:0]    tx_oe
);
  localparam int MAXB = NCH * SW;

  logic            frame_start;
  logic            active;
  layout_e         layout_q;
  logic [MAXB-1:0] frame_bytes;
  logic [MAXB-1:0] chain_word;
  logic [MAXB-1:0] split_word;
  logic [NCH-1:0]  lane_bit;
  logic            shift_en;

  pcm_tx_framer #(.NCH(NCH), .SW(SW)) u_framer (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .sync_in    (frame_sync),
    .pwr_on     (pwr_on),
    .chain_req  (chain_mode),
    .frame_start(frame_start),
    .active     (active),
    .layout_q   (layout_q)
  );

  pcm_tx_stage #(.NCH(NCH), .SW(SW), .FILL(FILL)) u_stage (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .in_valid   (smp_valid),
    .in_ready   (smp_ready),
    .in_data    (smp_data),
    .take       (frame_start),
    .ch_en      (ch_en),
    .frame_bytes(frame_bytes)
  );

  // channel 0 occupies the top byte so it leaves first
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chain_word[(NCH-c)*SW-1 -: SW] = frame_bytes[c*SW +: SW];
    end
    split_word = {frame_bytes[SW-1:0], {(MAXB-SW){1'b1}}};
  end

  assign shift_en = active & ~frame_start;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    if (c == 0) begin : g_wide
      pcm_tx_lane #(.LW(MAXB)) u_lane (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .load (frame_start),
        .shift(shift_en),
        .word (chain_mode ? chain_word : split_word),
        .bit_o(lane_bit[c])
      );
      assign tx_oe[c] = active;
    end else begin : g_narrow
      pcm_tx_lane #(.LW(SW)) u_lane (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .load (frame_start),
        .shift(shift_en),
        .word (frame_bytes[c*SW +: SW]),
        .bit_o(lane_bit[c])
      );
      assign tx_oe[c] = active & (layout_q == LAYOUT_SPLIT);
    end
    assign tx_d[c] = tx_oe[c] ? lane_bit[c] : 1'b1;
  end
endmodule

// File: rtl/pcm_tx_serializer_chk.sv
module pcm_tx_serializer_chk #(
  parameter int NCH = 3,
  parameter int SW  = 8
) (
  input logic              bit_clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              pwr_on,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [NCH-1:0]    tx_oe
);
  p_off_quiet_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !pwr_on |=> (tx_oe == '0));

  p_side_needs_main_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (|tx_oe[NCH-1:1]) |-> tx_oe[0]);

  p_side_lanes_together_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (tx_oe[NCH-1:1] == '0) || (&tx_oe[NCH-1:1]));

  p_start_on_edge_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pwr_on && frame_sync && !$past(frame_sync)) |=> tx_oe[0]);

  p_released_until_sync_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!pwr_on ##1 (pwr_on && !frame_sync)) |=> (tx_oe == '0));

  p_ready_drops_after_take_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

bind pcm_tx_serializer pcm_tx_serializer_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .bit_clk   (bit_clk),
  .rst_n     (rst_n),
  .frame_sync(frame_sync),
  .pwr_on    (pwr_on),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .tx_oe     (tx_oe)
);

// File: tb/pcm_tx_serializer_test.sv
module pcm_tx_serializer_test;
  localparam int CLK_NS = 10;

  logic        bit_clk = 1'b0;
  logic        rst_n;
  logic        frame_sync;
  logic        chain_mode;
  logic        pwr_on;
  logic [2:0]  ch_en;
  logic        smp_valid;
  logic        smp_ready;
  logic [23:0] smp_data;
  logic [2:0]  tx_d;
  logic [2:0]  tx_oe;

  pcm_tx_serializer uut (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .chain_mode(chain_mode), .pwr_on(pwr_on), .ch_en(ch_en),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .tx_d(tx_d), .tx_oe(tx_oe)
  );

  always #(CLK_NS/2) bit_clk = ~bit_clk;

  int    total = 0;
  int    bad   = 0;
  bit    run   = 0;
  bit    done  = 0;
  string phase = "R11";
  int    cyc   = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: act=%0h exp=%0h", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: bit queues per line plus a one-entry stage
  bit          q0[$];
  bit          q1[$];
  bit          q2[$];
  bit          m_prev;
  bit          m_full;
  logic [23:0] m_data;
  logic [23:0] m_last;

  always @(posedge bit_clk) begin
    cyc++;
    if (!rst_n) begin
      m_prev = 0; m_full = 0; m_data = '0; m_last = '1;
      q0.delete(); q1.delete(); q2.delete();
    end else begin
      bit fs, acc;
      logic [23:0] src;
      fs  = pwr_on && frame_sync && !m_prev;
      acc = smp_valid && !m_full;
      if (!pwr_on) begin
        q0.delete(); q1.delete(); q2.delete();
      end else if (fs) begin
        src = m_full ? m_data : m_last;
        m_last = src;
        m_full = 0;
        q0.delete(); q1.delete(); q2.delete();
        for (int c = 0; c < 3; c++) begin
          logic [7:0] b;
          b = ch_en[c] ? src[c*8 +: 8] : 8'hFF;
          for (int i = 7; i >= 0; i--) begin
            if (chain_mode || c == 0) q0.push_back(b[i]);
            else if (c == 1)          q1.push_back(b[i]);
            else                      q2.push_back(b[i]);
          end
        end
      end else begin
        if (q0.size() > 0) void'(q0.pop_front());
        if (q1.size() > 0) void'(q1.pop_front());
        if (q2.size() > 0) void'(q2.pop_front());
      end
      if (acc) begin
        m_full = 1;
        m_data = smp_data;
      end
      m_prev = frame_sync;
    end
  end

  always @(negedge bit_clk) begin
    if (run) begin
      logic [2:0] eo, ed;
      eo = {q2.size() > 0, q1.size() > 0, q0.size() > 0};
      ed[0] = (q0.size() > 0) ? q0[0] : 1'b1;
      ed[1] = (q1.size() > 0) ? q1[0] : 1'b1;
      ed[2] = (q2.size() > 0) ? q2[0] : 1'b1;
      chk(tx_oe == eo, {phase, " enables"}, 32'(tx_oe), 32'(eo));
      chk(tx_d == ed, {phase, " data"}, 32'(tx_d), 32'(ed));
      chk(smp_ready == !m_full, {phase, " ready"}, 32'(smp_ready), 32'(!m_full));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge bit_clk);
  endtask

  task automatic push(input logic [23:0] v);
    smp_valid = 1'b1;
    smp_data  = v;
    tick(1);
    smp_valid = 1'b0;
  endtask

  task automatic frame(input int sync_len, input int len);
    frame_sync = 1'b1;
    tick(sync_len);
    frame_sync = 1'b0;
    tick(len - sync_len);
  endtask

  initial begin
    rst_n = 0; frame_sync = 0; chain_mode = 0; pwr_on = 1;
    ch_en = 3'b111; smp_valid = 0; smp_data = '0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk(tx_oe == 3'b000, "R11 released", 32'(tx_oe), 0);
    chk(smp_ready == 1'b1, "R11 ready", 32'(smp_ready), 1);
    run = 1;

    phase = "R2";
    push(24'hA5_3C_81);
    frame_sync = 1'b1;
    tick(1);
    chk(tx_oe == 3'b111, "R2 first slot enabled", 32'(tx_oe), 32'h7);
    chk(tx_d == 3'b101, "R2 first bit is MSB", 32'(tx_d), 32'h5);
    frame_sync = 1'b0;
    tick(31);
    chk(tx_oe == 3'b000, "R4 released after slots", 32'(tx_oe), 0);

    phase = "R1";
    push(24'h0F_F0_5A);
    frame(1, 32);
    push(24'h7E_01_C3);
    frame(2, 32);

    phase = "R8";
    push(24'h12_34_56);
    frame(1, 10);
    push(24'h9A_BC_DE);
    tick(22);
    frame(1, 32);
    frame(1, 32);

    phase = "R9";
    push(24'h66_99_33);
    frame(20, 40);

    phase = "R3";
    chain_mode = 1'b1;
    push(24'hC0_FF_EE);
    frame(1, 32);
    frame(3, 32);

    phase = "R12";
    push(24'h11_22_33);
    frame_sync = 1'b1;
    tick(1);
    frame_sync = 1'b0;
    tick(2);
    chain_mode = 1'b0;
    ch_en = 3'b010;
    tick(29);
    ch_en = 3'b111;
    frame(1, 32);

    phase = "R6";
    ch_en = 3'b101;
    push(24'h00_00_00);
    frame(1, 32);
    ch_en = 3'b010;
    chain_mode = 1'b1;
    frame(1, 32);
    ch_en = 3'b111;
    chain_mode = 1'b0;

    phase = "R10";
    push(24'h5A_A5_3C);
    frame(1, 4);
    frame(1, 32);

    phase = "R5";
    push(24'hDE_AD_17);
    frame(1, 3);
    pwr_on = 1'b0;
    tick(4);
    frame(1, 10);
    chk(tx_oe == 3'b000, "R5 released while off", 32'(tx_oe), 0);

    phase = "R7";
    pwr_on = 1'b1;
    tick(10);
    chk(tx_oe == 3'b000, "R7 released before sync", 32'(tx_oe), 0);
    frame(1, 32);

    run = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge bit_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule